// File: doc/BRIEF.md
# Misaligned-Capable Load Alignment Unit

This block services one integer load at a time against a byte-addressed memory that is built from aligned 64-bit doublewords. A request gives a base value, a signed 16-bit displacement, an access width (1, 2, 4 or 8 bytes), a sign-extension flag and a byte-order flag. The unit forms the effective address and decides whether the access is aligned. It then reads one aligned doubleword, or two consecutive ones when the access is misaligned. From the fetched bytes it assembles the value in the chosen byte order and widens it to 64 bits.

The requester side is a valid signal that is taken only while the unit is idle, a busy flag, and a one-cycle result strobe. The memory side is a valid/ready address channel, followed by a response strobe that carries 64 bits of read data. At most one memory read is outstanding at any time.

Top module: `load_align_unit`

## Requirements
- R1: After reset the unit is idle: `req_ready`=1, `busy`=0, `mem_req_valid`=0 and `res_valid`=0.
- R2: The effective address is `req_base` plus `req_disp` sign-extended to 64 bits, modulo 2^64. A zero base or a zero displacement therefore simply yields the other operand.
- R3: `req_size` encodes the width as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. An access whose effective address is a multiple of its width issues exactly one memory read. A 1-byte access is always treated this way.
- R4: A misaligned access issues exactly two memory reads. The first is at the effective address with its low three bits cleared; the second is 8 above it. This holds even when every addressed byte lies within the first doubleword.
- R5: Within `mem_rsp_data`, bits [8k+7:8k] hold the byte at the read address plus k. With `req_big_endian`=0, the byte at the effective address becomes the least significant byte of the result.
- R6: With `req_big_endian`=1, the byte at the effective address becomes the most significant byte of the accessed width, and the following bytes fill in toward the least significant byte.
- R7: For widths below 8 bytes, the upper result bits are copies of the value's top bit when `req_signed`=1 and zeros when it is 0. An 8-byte result is the assembled value unchanged for either flag value.
- R8: Once `mem_req_valid` is raised it stays high, with `mem_req_addr` unchanged, until the cycle in which `mem_req_ready` is high. Every request address has its low three bits at zero.
- R9: A load is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle through the cycle of the result. `res_valid` is a single-cycle pulse, and `busy` is low in the following cycle. A `req_valid` seen while busy has no effect on the result or on the memory reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle; a request is taken this cycle |
| req_base | input | 64 | Base value of the address |
| req_disp | input | 16 | Signed displacement |
| req_size | input | 2 | Access width code |
| req_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| req_big_endian | input | 1 | 1 = big-endian byte order |
| busy | output | 1 | Load in progress |
| mem_req_valid | output | 1 | Memory read address valid |
| mem_req_ready | input | 1 | Memory takes the address |
| mem_req_addr | output | 64 | Doubleword-aligned read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, byte k in bits [8k+7:8k] |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 64 | Extended load value, meaningful with res_valid |

## Verification
The checks assume that the memory raises `mem_rsp_valid` only after it has taken an address and before the unit issues the next one, and only once per accepted address. They also assume `mem_rsp_valid` never arrives in the same cycle that the address is taken. The bench memory model follows these rules by construction: it answers each accepted address exactly once, two cycles later. It also lowers `mem_req_ready` in a repeating pattern, so that held requests actually occur, and computes every byte from its address instead of storing it.

// File: rtl/lau_pkg.sv
package lau_pkg;
  localparam int LAU_SIZE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE0,
    ST_WAIT0,
    ST_ISSUE1,
    ST_WAIT1,
    ST_DONE
  } lau_state_e;

  typedef struct packed {
    logic [LAU_SIZE_W-1:0] size;
    logic                  sgn;
    logic                  big;
  } lau_mode_t;
endpackage

// File: rtl/lau_addr_gen.sv
module lau_addr_gen
  import lau_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [ADDR_W-1:0]     base,
  input  logic [DISP_W-1:0]     disp,
  input  logic [LAU_SIZE_W-1:0] size,
  output logic [ADDR_W-1:0]     ea,
  output logic                  split
);
  function automatic logic [ADDR_W-1:0] calc_ea(input logic [ADDR_W-1:0] b,
                                                input logic [DISP_W-1:0] d);
    return b + {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic is_misaligned(input logic [OFF_W-1:0] low,
                                         input logic [LAU_SIZE_W-1:0] sz);
    logic [OFF_W:0] m;
    m = ((OFF_W+1)'(1) << sz) - (OFF_W+1)'(1);
    return (low & m[OFF_W-1:0]) != '0;
  endfunction

  always_comb begin
    ea    = calc_ea(base, disp);
    split = is_misaligned(ea[OFF_W-1:0], size);
  end

  // R3
  always_comb begin
    if (size == '0) begin
      byte_access_single_chk: assert (!split);
    end
  end
endmodule

// File: rtl/lau_byte_merge.sv
module lau_byte_merge
  import lau_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0]     lo_dw,
  input  logic [DATA_W-1:0]     hi_dw,
  input  logic [OFF_W-1:0]      off,
  input  lau_mode_t             mode,
  output logic [DATA_W-1:0]     value
);
  logic [2*DATA_W-1:0] win;
  logic [7:0]          g [NB];
  logic [OFF_W:0]      m;
  logic [OFF_W-1:0]    last;
  logic                msb;

  always_comb begin
    win  = {hi_dw, lo_dw} >> {off, 3'b000};
    for (int i = 0; i < NB; i++) g[i] = win[8*i +: 8];
    m    = ((OFF_W+1)'(1) << mode.size) - (OFF_W+1)'(1);
    last = m[OFF_W-1:0];
    msb  = mode.big ? g[0][7] : g[last][7];
    value = '0;
    for (int i = 0; i < NB; i++) begin
      if (OFF_W'(i) <= last) begin
        value[8*i +: 8] = mode.big ? g[last - OFF_W'(i)] : g[OFF_W'(i)];
      end else begin
        value[8*i +: 8] = {8{mode.sgn & msb}};
      end
    end
  end
endmodule

// File: rtl/lau_ctrl.sv
module lau_ctrl
  import lau_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_ea,
  input  lau_mode_t         req_mode,
  input  logic              req_split,
  output logic              req_ready,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output lau_mode_t         cap_mode,
  output logic [OFF_W-1:0]  cap_off,
  output logic [DATA_W-1:0] lo_dw,
  output logic [DATA_W-1:0] hi_dw
);
  lau_state_e        state, state_nx;
  logic [ADDR_W-1:0] dw_q;
  logic              split_q;
  logic              accept;
  logic              addr_take;
  logic              waiting;

  assign accept    = req_valid && (state == ST_IDLE);
  assign addr_take = mem_req_valid && mem_req_ready;
  assign waiting   = (state == ST_WAIT0) || (state == ST_WAIT1);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (req_valid) state_nx = ST_ISSUE0;
      ST_ISSUE0: if (mem_req_ready) state_nx = ST_WAIT0;
      ST_WAIT0:  if (mem_rsp_valid) state_nx = split_q ? ST_ISSUE1 : ST_DONE;
      ST_ISSUE1: if (mem_req_ready) state_nx = ST_WAIT1;
      ST_WAIT1:  if (mem_rsp_valid) state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dw_q     <= '0;
      split_q  <= 1'b0;
      cap_mode <= '0;
      cap_off  <= '0;
      lo_dw    <= '0;
      hi_dw    <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        dw_q     <= {req_ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        cap_off  <= req_ea[OFF_W-1:0];
        cap_mode <= req_mode;
        split_q  <= req_split;
      end
      if (state == ST_WAIT0 && mem_rsp_valid) lo_dw <= mem_rsp_data;
      if (state == ST_WAIT1 && mem_rsp_valid) hi_dw <= mem_rsp_data;
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE0) || (state == ST_ISSUE1);
  assign mem_req_addr  = (state == ST_ISSUE1) ? dw_q + ADDR_W'(NB) : dw_q;
  assign res_valid     = (state == ST_DONE);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8
  req_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && !busy));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && mem_req_valid));

  // R4
  rsp_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> waiting);

  // R3
  second_read_needs_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ISSUE1) |-> (cap_mode.size != '0));
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import lau_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [DISP_W-1:0]     req_disp,
  input  logic [LAU_SIZE_W-1:0] req_size,
  input  logic                  req_signed,
  input  logic                  req_big_endian,
  output logic                  busy,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [DATA_W-1:0]     mem_rsp_data,
  output logic                  res_valid,
  output logic [DATA_W-1:0]     res_data
);
  logic [ADDR_W-1:0] ea;
  logic              split;
  lau_mode_t         in_mode;
  lau_mode_t         cap_mode;
  logic [OFF_W-1:0]  cap_off;
  logic [DATA_W-1:0] lo_dw;
  logic [DATA_W-1:0] hi_dw;

  assign in_mode = '{size: req_size, sgn: req_signed, big: req_big_endian};

  lau_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .DATA_W(DATA_W)) addr_i (
    .base (req_base),
    .disp (req_disp),
    .size (req_size),
    .ea   (ea),
    .split(split)
  );

  lau_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ea       (ea),
    .req_mode     (in_mode),
    .req_split    (split),
    .req_ready    (req_ready),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .res_valid    (res_valid),
    .cap_mode     (cap_mode),
    .cap_off      (cap_off),
    .lo_dw        (lo_dw),
    .hi_dw        (hi_dw)
  );

  lau_byte_merge #(.DATA_W(DATA_W)) merge_i (
    .lo_dw(lo_dw),
    .hi_dw(hi_dw),
    .off  (cap_off),
    .mode (cap_mode),
    .value(res_data)
  );

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !mem_req_valid && !res_valid));
endmodule

// File: tb/load_align_unit_tb_top.sv
`timescale 1ns/1ps
module load_align_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        req_big_endian = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  load_align_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_disp(req_disp), .req_size(req_size),
    .req_signed(req_signed), .req_big_endian(req_big_endian), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[63:60], a[35:32]} ^ 8'h3C;
  endfunction

  function automatic logic [63:0] mem_dw(input logic [63:0] a);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = mem_byte(a + 64'(k));
    return d;
  endfunction

  // memory model
  logic [7:0]  cyc = '0;
  logic        pend = 1'b0;
  logic [1:0]  lat = '0;
  logic [63:0] paddr = '0;
  int          nreq = 0;
  logic [63:0] req_log [4];
  int          stall_seen = 0;
  int          hold_viol = 0;
  logic        prev_v = 1'b0, prev_r = 1'b0;
  logic [63:0] prev_a = '0;

  assign mem_req_ready = (cyc % 8'd3) != 8'd1;

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (!rst_n) begin
      pend <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend && lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_dw(paddr);
        pend <= 1'b0;
      end else if (pend) begin
        lat <= lat - 2'd1;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend  <= 1'b1;
        lat   <= 2'd1;
        paddr <= mem_req_addr;
        req_log[nreq % 4] <= mem_req_addr;
        nreq  <= nreq + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && !prev_r) begin
        stall_seen++;
        if (!mem_req_valid || mem_req_addr != prev_a) hold_viol++;
      end
      if (mem_req_valid && mem_req_addr[2:0] != 3'b0) hold_viol++;
    end
    prev_v = mem_req_valid;
    prev_r = mem_req_ready;
    prev_a = mem_req_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_val(input logic [63:0] ea, input int nb,
                                             input bit sgn, input bit big);
    logic [63:0] v = '0;
    logic top;
    for (int i = 0; i < nb; i++) begin
      if (big) v = (v << 8) | 64'(mem_byte(ea + 64'(i)));
      else     v = v | (64'(mem_byte(ea + 64'(i))) << (8 * i));
    end
    top = v[8*nb-1];
    if (sgn && top && nb < 8) v = v | (~64'(0) << (8 * nb));
    return v;
  endfunction

  // one load; intrude=1 drives a second request while busy (R9)
  task automatic do_load(input logic [63:0] base, input logic [15:0] disp,
                         input logic [1:0] size, input bit sgn, input bit big,
                         input string req, input bit intrude);
    logic [63:0] ea, exp;
    int nb, n0, wd;
    bit mis;
    ea  = base + {{48{disp[15]}}, disp};
    nb  = 1 << size;
    mis = (ea % 64'(nb)) != 0;
    exp = expect_val(ea, nb, sgn, big);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n0 = nreq;
    req_base = base; req_disp = disp; req_size = size;
    req_signed = sgn; req_big_endian = big; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    if (intrude) begin
      req_base = base + 64'h40; req_size = ~size; req_big_endian = ~big;
      req_signed = ~sgn; req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    wd = 0;
    while (res_valid !== 1'b1 && wd < 200) begin
      @(negedge clk);
      wd++;
    end
    chk(wd < 200, "R9 result arrives", 64'(wd), 64'd0);
    chk(res_data === exp, req, res_data, exp);
    chk(busy === 1'b1, "R9 busy during result", 64'(busy), 64'd1);
    chk((nreq - n0) == (mis ? 2 : 1), mis ? "R4 two reads" : "R3 one read",
        64'(nreq - n0), mis ? 64'd2 : 64'd1);
    chk(req_log[n0 % 4] === {ea[63:3], 3'b0}, "R2 first read address",
        req_log[n0 % 4], {ea[63:3], 3'b0});
    if (mis)
      chk(req_log[(n0 + 1) % 4] === {ea[63:3], 3'b0} + 64'd8, "R4 second read address",
          req_log[(n0 + 1) % 4], {ea[63:3], 3'b0} + 64'd8);
    @(negedge clk);
    chk(res_valid === 1'b0 && busy === 1'b0, "R9 single pulse then idle",
        {62'b0, res_valid, busy}, 64'd0);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(res_valid === 1'b0, "R1 res_valid", 64'(res_valid), 64'd0);
  endtask

  task automatic t_aligned_le();
    do_load(64'h1000, 16'h0000, 2'd3, 1'b0, 1'b0, "R5 8B aligned LE", 1'b0);
    do_load(64'h1000, 16'h0004, 2'd2, 1'b0, 1'b0, "R5 4B aligned LE", 1'b0);
    do_load(64'h1000, 16'h0006, 2'd1, 1'b0, 1'b0, "R5 2B aligned LE", 1'b0);
    for (int o = 0; o < 8; o++)
      do_load(64'h2000, 16'(o), 2'd0, 1'b0, 1'b0, "R3 byte any offset", 1'b0);
  endtask

  task automatic t_misaligned();
    do_load(64'h3000, 16'h0007, 2'd1, 1'b0, 1'b0, "R4 2B crossing", 1'b0);
    do_load(64'h3000, 16'h0002, 2'd2, 1'b0, 1'b0, "R4 4B inside one dw", 1'b0);
    do_load(64'h3000, 16'h0003, 2'd3, 1'b0, 1'b0, "R4 8B off 3", 1'b0);
    do_load(64'h3000, 16'h0005, 2'd2, 1'b1, 1'b1, "R4 4B crossing BE", 1'b0);
  endtask

  task automatic t_big_endian();
    do_load(64'h4008, 16'h0000, 2'd3, 1'b0, 1'b1, "R6 8B BE", 1'b0);
    do_load(64'h4008, 16'h0004, 2'd2, 1'b0, 1'b1, "R6 4B BE", 1'b0);
    do_load(64'h4008, 16'h0001, 2'd1, 1'b0, 1'b1, "R6 2B BE misaligned", 1'b0);
  endtask

  task automatic t_extend();
    // search offsets giving a set and a clear top byte bit
    for (int o = 0; o < 16; o++) begin
      do_load(64'h5000, 16'(o), 2'd0, 1'b1, 1'b0, "R7 1B signed", 1'b0);
      do_load(64'h5000, 16'(2 * o), 2'd1, 1'b1, 1'b0, "R7 2B signed", 1'b0);
    end
    do_load(64'h5010, 16'h0000, 2'd2, 1'b1, 1'b1, "R7 4B signed BE", 1'b0);
    do_load(64'h5010, 16'h0000, 2'd2, 1'b0, 1'b1, "R7 4B unsigned BE", 1'b0);
    do_load(64'h5018, 16'h0000, 2'd3, 1'b1, 1'b0, "R7 8B signed unchanged", 1'b0);
    do_load(64'h5019, 16'h0000, 2'd3, 1'b1, 1'b1, "R7 8B signed BE unchanged", 1'b0);
  endtask

  task automatic t_disp();
    do_load(64'h6010, 16'hFFF8, 2'd3, 1'b0, 1'b0, "R2 negative disp", 1'b0);
    do_load(64'h6013, 16'h0000, 2'd0, 1'b0, 1'b0, "R2 zero disp", 1'b0);
    do_load(64'h0000, 16'h7FF4, 2'd2, 1'b0, 1'b0, "R2 zero base", 1'b0);
    do_load(64'h0000, 16'h8001, 2'd1, 1'b1, 1'b0, "R2 wrap negative", 1'b0);
    do_load(64'hF000_0000_0000_0100, 16'h0006, 2'd2, 1'b0, 1'b0, "R2 high base", 1'b0);
  endtask

  task automatic t_busy_ignore();
    do_load(64'h7000, 16'h0003, 2'd1, 1'b0, 1'b0, "R9 ignored while busy", 1'b1);
    do_load(64'h7008, 16'h0000, 2'd3, 1'b0, 1'b1, "R9 ignored while busy 8B", 1'b1);
  endtask

  task automatic t_handshake();
    chk(stall_seen > 0, "R8 stalls exercised", 64'(stall_seen), 64'd1);
    chk(hold_viol == 0, "R8 request held and aligned", 64'(hold_viol), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned_le();
    t_misaligned();
    t_big_endian();
    t_extend();
    t_disp();
    t_busy_ignore();
    t_handshake();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule